// File: doc/BRIEF.md
# PWM Global Channel Control Register File

This block holds the chip-wide control registers of a multi-channel pulse-width modulator. Every register uses one bit per channel. Channels are started and stopped through two separate write-one addresses, so software never needs a read-modify-write. A status word reads back which channels are running. The interrupt mask works the same way: one address arms bits, another disarms them, and a third reads the armed set. A clock-mode word is stored as-is and driven out to the clock dividers.

The per-channel counters sit outside this block. Each counter sends a one-cycle end-of-period pulse, and the block latches it into a pending word. Reading that word returns the latched bits and clears them. The single interrupt line is high while any pending bit is also armed. The bus is a simple word-addressed read/write strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `pwm_gctl`

## Requirements
- R1: After synchronous reset, `ch_run`, the mask, the pending word, `clk_cfg` and `irq` are all zero.
- R2: A write to byte offset 0x04 sets `ch_run[n]` in the next cycle for every data bit n that is 1. Data bits that are 0 leave their channels unchanged.
- R3: A write to offset 0x08 clears `ch_run[n]` for every data bit n that is 1, and leaves the other channels alone. A read of offset 0x0C returns `ch_run` in bits [NUM_CH-1:0], with the upper bits zero.
- R4: A write to offset 0x10 arms mask bit n for each 1 in the data. A write to offset 0x14 disarms mask bit n for each 1 in the data. A read of offset 0x18 returns the mask.
- R5: A pulse on `period_evt[n]` sets pending bit n in the next cycle, whether or not that bit is armed.
- R6: A read of offset 0x1C returns the pending word and clears the bits it reported. An event that arrives in the same cycle as that read stays pending.
- R7: `irq` is high exactly when (pending AND mask) is non-zero. It tracks the same clock edge that updates pending or mask.
- R8: Offset 0x00 is a full-width read/write mode word, and its stored value drives `clk_cfg`.
- R9: Writing all ones to 0x08 and then to 0x14 stops every channel and disarms every interrupt.
- R10: `bus_rdata` is valid in the cycle after `bus_rd`. Writes to the read-only offsets 0x0C, 0x18 and 0x1C change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| period_evt | input | NUM_CH | End-of-period pulses from the channel counters |
| ch_run | output | NUM_CH | Channel run enables |
| clk_cfg | output | DATA_W | Stored mode word |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land on the same clock edge: a read of the pending word, which clears the bits it reports, and a new end-of-period pulse. The bench provokes this by raising the read strobe and a pulse on a channel that is not yet pending in the same cycle. It then checks three things: the read returns only the bits that were pending before that edge, the new bit survives, and a second read returns that bit alone. The interrupt line is judged across that same edge against the armed set.

// File: rtl/pwm_gctl_pkg.sv
package pwm_gctl_pkg;
  // word index = byte offset >> 2
  typedef enum logic [2:0] {
    RG_MODE     = 3'd0,
    RG_RUN_SET  = 3'd1,
    RG_RUN_CLR  = 3'd2,
    RG_RUN_STAT = 3'd3,
    RG_IRQ_SET  = 3'd4,
    RG_IRQ_CLR  = 3'd5,
    RG_IRQ_MASK = 3'd6,
    RG_EVT_STAT = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/pwm_gctl_setclr.sv
module pwm_gctl_setclr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      nxt_o[b] = q[b];
      if (set_i[b]) nxt_o[b] = 1'b1;
      else if (clr_i[b]) nxt_o[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end

  assign q_o = q;

  // R2 / R4: set bits land, other bits hold
  a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0 && clr_i == '0) |=> ((q_o & $past(set_i)) == $past(set_i)) &&
                                     ((q_o & ~$past(set_i)) == ($past(q_o) & ~$past(set_i))));
  // R3 / R4: clear bits drop, other bits hold
  a_r3_clr_lands: assert property (@(posedge clk) disable iff (rst)
    (clr_i != '0 && set_i == '0) |=> ((q_o & $past(clr_i)) == '0) &&
                                     ((q_o & ~$past(clr_i)) == ($past(q_o) & ~$past(clr_i))));
endmodule

// File: rtl/pwm_gctl_pending.sv
module pwm_gctl_pending #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         ack_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] q;
  logic [W-1:0] keep;

  assign keep  = ack_i ? '0 : q;
  assign nxt_o = keep | evt_i;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end

  assign q_o = q;

  // R5 / R6: an event is never lost, even against an acknowledging read
  a_r6_evt_kept: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((q_o & $past(evt_i)) == $past(evt_i)));
  // R6: acknowledge with no new event empties the word
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_i && evt_i == '0) |=> (q_o == '0));
endmodule

// File: rtl/pwm_gctl.sv
module pwm_gctl
  import pwm_gctl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] period_evt,
  output logic [NUM_CH-1:0] ch_run,
  output logic [DATA_W-1:0] clk_cfg,
  output logic              irq
);
  localparam int IDX_LSB = 2;
  localparam int IDX_W   = 3;
  localparam int SPAN    = IDX_LSB + IDX_W;

  logic     hit;
  reg_idx_e idx;
  logic [NUM_CH-1:0] wbits;
  logic [NUM_CH-1:0] run_set, run_clr, msk_set, msk_clr;
  logic [NUM_CH-1:0] run_q, run_d, msk_q, msk_d, pnd_q, pnd_d;
  logic              ack;
  logic [DATA_W-1:0] mode_q, rd_word, rdata_q;
  logic              irq_q;

  assign hit   = ((bus_addr >> SPAN) == '0);
  assign idx   = reg_idx_e'(bus_addr[IDX_LSB +: IDX_W]);
  assign wbits = bus_wdata[NUM_CH-1:0];

  always_comb begin
    run_set = '0; run_clr = '0; msk_set = '0; msk_clr = '0;
    if (bus_wr && hit) begin
      unique case (idx)
        RG_RUN_SET: run_set = wbits;
        RG_RUN_CLR: run_clr = wbits;
        RG_IRQ_SET: msk_set = wbits;
        RG_IRQ_CLR: msk_clr = wbits;
        default: ;
      endcase
    end
  end

  assign ack = bus_rd && hit && (idx == RG_EVT_STAT);

  pwm_gctl_setclr #(.W(NUM_CH)) u_run (
    .clk(clk), .rst(rst), .set_i(run_set), .clr_i(run_clr),
    .q_o(run_q), .nxt_o(run_d));

  pwm_gctl_setclr #(.W(NUM_CH)) u_mask (
    .clk(clk), .rst(rst), .set_i(msk_set), .clr_i(msk_clr),
    .q_o(msk_q), .nxt_o(msk_d));

  pwm_gctl_pending #(.W(NUM_CH)) u_pend (
    .clk(clk), .rst(rst), .evt_i(period_evt), .ack_i(ack),
    .q_o(pnd_q), .nxt_o(pnd_d));

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (bus_wr && hit && idx == RG_MODE) mode_q <= bus_wdata;
  end

  always_comb begin
    rd_word = '0;
    if (hit) begin
      unique case (idx)
        RG_MODE:     rd_word = mode_q;
        RG_RUN_STAT: rd_word[NUM_CH-1:0] = run_q;
        RG_IRQ_MASK: rd_word[NUM_CH-1:0] = msk_q;
        RG_EVT_STAT: rd_word[NUM_CH-1:0] = pnd_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_word;
      irq_q <= |(pnd_d & msk_d);
    end
  end

  assign bus_rdata = rdata_q;
  assign ch_run    = run_q;
  assign clk_cfg   = mode_q;
  assign irq       = irq_q;

  // R7: interrupt line agrees with the registered pending and mask words
  a_r7_irq_match: assert property (@(posedge clk) disable iff (rst)
    irq == (|(pnd_q & msk_q)));
  // R1: first cycle out of reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ch_run == '0 && msk_q == '0 && pnd_q == '0 && !irq));
  // R10: writes to read-only words leave state untouched
  a_r10_ro_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit && (idx == RG_RUN_STAT || idx == RG_IRQ_MASK)) |=>
      ($stable(ch_run) && $stable(msk_q)));
endmodule

// File: tb/tb_pwm_gctl.sv
module tb_pwm_gctl;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NCH-1:0] period_evt = '0;
  logic [NCH-1:0] ch_run;
  logic [DW-1:0] clk_cfg;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_gctl #(.NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .period_evt(period_evt), .ch_run(ch_run), .clk_cfg(clk_cfg), .irq(irq));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] e);
    @(negedge clk);
    period_evt = e;
    @(negedge clk);
    period_evt = '0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 ch_run", DW'(ch_run), '0);
    chk("R1 irq", DW'(irq), '0);
    chk("R1 clk_cfg", clk_cfg, '0);
    rd(5'h18, v); chk("R1 mask", v, '0);
    rd(5'h1C, v); chk("R1 pending", v, '0);
  endtask

  task automatic t_enable();
    logic [DW-1:0] v;
    wr(5'h04, 32'h5); chk("R2 set 0,2", DW'(ch_run), 32'h5);
    wr(5'h04, 32'h2); chk("R2 zeros keep", DW'(ch_run), 32'h7);
    rd(5'h0C, v); chk("R3 status read", v, 32'h7);
  endtask

  task automatic t_disable();
    wr(5'h08, 32'h4); chk("R3 clear 2", DW'(ch_run), 32'h3);
    wr(5'h08, 32'h0); chk("R3 zero write", DW'(ch_run), 32'h3);
  endtask

  task automatic t_mask();
    logic [DW-1:0] v;
    wr(5'h10, 32'hB); rd(5'h18, v); chk("R4 arm", v, 32'hB);
    wr(5'h14, 32'h8); rd(5'h18, v); chk("R4 disarm", v, 32'h3);
  endtask

  task automatic t_event_irq();
    logic [DW-1:0] v;
    pulse(4'h4);
    chk("R5 unarmed pending irq", DW'(irq), '0);
    pulse(4'h1);
    chk("R7 armed irq", DW'(irq), 32'h1);
    rd(5'h1C, v); chk("R5 pending read", v, 32'h5);
    chk("R6 cleared irq", DW'(irq), '0);
    rd(5'h1C, v); chk("R6 read clears", v, '0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] v;
    pulse(4'h1);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 5'h1C; period_evt = 4'h2;
    @(negedge clk);
    bus_rd = 1'b0; period_evt = '0;
    chk("R6 collide read", bus_rdata, 32'h1);
    chk("R7 collide irq", DW'(irq), 32'h1);
    rd(5'h1C, v); chk("R6 event kept", v, 32'h2);
    chk("R7 after drain", DW'(irq), '0);
  endtask

  task automatic t_irq_mask_change();
    pulse(4'h8);
    chk("R7 unarmed", DW'(irq), '0);
    wr(5'h10, 32'h8);
    chk("R7 arm raises", DW'(irq), 32'h1);
    wr(5'h14, 32'h8);
    chk("R7 disarm drops", DW'(irq), '0);
    begin logic [DW-1:0] v; rd(5'h1C, v); end
  endtask

  task automatic t_mode();
    logic [DW-1:0] v;
    wr(5'h00, 32'hA5C3_0F01);
    chk("R8 clk_cfg", clk_cfg, 32'hA5C3_0F01);
    rd(5'h00, v); chk("R8 read", v, 32'hA5C3_0F01);
  endtask

  task automatic t_readonly();
    logic [DW-1:0] v;
    wr(5'h0C, 32'hF); chk("R10 ro status", DW'(ch_run), 32'h3);
    wr(5'h18, 32'hF); rd(5'h18, v); chk("R10 ro mask", v, 32'h3);
    pulse(4'h2);
    wr(5'h1C, 32'hF); rd(5'h1C, v); chk("R10 ro pending", v, 32'h2);
  endtask

  task automatic t_shutdown();
    logic [DW-1:0] v;
    wr(5'h04, 32'hF); wr(5'h10, 32'hF);
    wr(5'h08, 32'hFFFF_FFFF); wr(5'h14, 32'hFFFF_FFFF);
    chk("R9 all stopped", DW'(ch_run), '0);
    rd(5'h18, v); chk("R9 all disarmed", v, '0);
    pulse(4'hF);
    chk("R9 no irq", DW'(irq), '0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable();
    t_disable();
    t_mask();
    t_event_irq();
    t_collide();
    t_irq_mask_change();
    t_mode();
    t_readonly();
    t_shutdown();
    summary();
  end
endmodule